// File: doc/BRIEF.md
# Vector Memory Request Sequencer

This block turns one vector load or store into a series of memory request beats. Each beat gives a byte address and the number of the register that the beat targets. A start pulse captures the whole operation: the base address, the element width code, a unit-or-constant stride choice with its stride value, an indexed-mode flag with one offset for each element, the vector length, the segment count and a predicate mask. The block then walks the elements in order. For each active element it emits one beat per segment field. The beats leave through a valid/ready handshake.

Elements whose predicate bit is clear produce no beat. When the last beat of the operation has been accepted, a one-cycle completion pulse follows. The pulse also comes when no beat was produced at all. A reserved width code produces an error pulse and no traffic. The block does not return data, translate addresses or handle faults.

Top module: `vldst_addr_gen`

## Requirements
- R1: Element width code maps to bytes as 1→1, 2→2, 3→4, 4→8, 5→16 and 0→AW/8. In unit-stride mode (`const_stride`=0) the stride equals these element bytes.
- R2: With `const_stride`=1 the stride is `stride_val`. In non-indexed mode, element i segment j is sent to base + i*(seg_len+1)*stride + j*stride, modulo 2^AW.
- R3: With `indexed`=1, element i segment j is sent to base + off[i] + j*stride. Here off[i] is bits [i*AW +: AW] of `idx_offsets`.
- R4: The register of each beat is (dest_reg + j) mod 32.
- R5: Beats come element-major: element index ascending, and for each element the segment index j runs from 0 to seg_len. `req_elem` and `req_seg` report i and j.
- R6: An element i with `pred_mask[i]`=0 produces no beat.
- R7: Width codes 6 and 7 produce a one-cycle `err` pulse in the cycle after start. They produce no beat, no `done` and no busy period.
- R8: A beat that is offered and not accepted stays valid, with unchanged address and register, until it is accepted.
- R9: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. With every element masked, or with vec_len = 0, it is high in the cycle after the last element was scanned.
- R10: `start` is ignored while `busy` is high. vec_len must not exceed MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture operation (when idle) |
| width_code | input | 3 | Element width code |
| const_stride | input | 1 | 1: use stride_val, 0: stride is element size |
| stride_val | input | AW | Constant stride in bytes |
| indexed | input | 1 | Use per-element offsets |
| idx_offsets | input | MAXVL*AW | Per-element offsets, element i at [i*AW +: AW] |
| base_addr | input | AW | Base byte address |
| vec_len | input | LW | Number of elements |
| seg_len | input | SW | Segment fields per element minus one |
| pred_mask | input | MAXVL | Per-element enable |
| dest_reg | input | 5 | First destination register |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | Beat valid |
| req_ready | input | 1 | Beat accepted |
| req_addr | output | AW | Beat byte address |
| req_reg | output | 5 | Beat register number |
| req_elem | output | LW | Element index of beat |
| req_seg | output | SW | Segment index of beat |
| done | output | 1 | Completion pulse |
| err | output | 1 | Reserved width code pulse |

## Verification
Several rules are checked on every cycle. A stalled beat must hold its address and register. The completion pulse must be one cycle wide and must leave the block idle. No beat may appear while the block is idle or while an error is signalled. The segment index must never pass the captured segment count. Address arithmetic, register numbering, predicate skipping, order and the timing of the completion pulse are shown only by the bench scenarios. These run directed corner cases and random operations under random back-pressure, and compare each beat against a model of the addressing rules.

// File: rtl/vldst_addr_gen.sv
module vldst_addr_gen #(
  parameter int AW    = 32,
  parameter int MAXVL = 8,
  parameter int SW    = 3,
  localparam int LW   = $clog2(MAXVL + 1),
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          width_code,
  input  logic                const_stride,
  input  logic [AW-1:0]       stride_val,
  input  logic                indexed,
  input  logic [MAXVL*AW-1:0] idx_offsets,
  input  logic [AW-1:0]       base_addr,
  input  logic [LW-1:0]       vec_len,
  input  logic [SW-1:0]       seg_len,
  input  logic [MAXVL-1:0]    pred_mask,
  input  logic [4:0]          dest_reg,
  output logic                busy,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  output logic [4:0]          req_reg,
  output logic [LW-1:0]       req_elem,
  output logic [SW-1:0]       req_seg,
  output logic                done,
  output logic                err
);
  logic [AW-1:0]       base_q, stride_q, estep_q, eoff, soff;
  logic [MAXVL*AW-1:0] idx_q;
  logic [MAXVL-1:0]    pred_q;
  logic [LW-1:0]       vl_q, elem;
  logic [SW-1:0]       seg_q, seg;
  logic [4:0]          rd_q;
  logic                idx_mode_q;
  logic [AW-1:0]       esz, stride_sel, cur_idx;
  logic                in_range, cur_pred, last_seg, step_elem, reserved;

  always_comb begin
    case (width_code)
      3'd1:    esz = AW'(1);
      3'd2:    esz = AW'(2);
      3'd3:    esz = AW'(4);
      3'd4:    esz = AW'(8);
      3'd5:    esz = AW'(16);
      3'd0:    esz = AW'(AW / 8);
      default: esz = '0;
    endcase
  end

  assign reserved   = width_code[2] & width_code[1];
  assign stride_sel = const_stride ? stride_val : esz;
  assign in_range   = elem < vl_q;
  assign cur_pred   = in_range & pred_q[elem[IW-1:0]];
  assign cur_idx    = idx_q[elem[IW-1:0]*AW +: AW];
  assign last_seg   = seg == seg_q;
  assign step_elem  = busy & in_range & (~cur_pred | (req_ready & last_seg));

  assign req_valid = busy & cur_pred;
  assign req_addr  = base_q + (idx_mode_q ? cur_idx : eoff) + soff;
  assign req_reg   = rd_q + 5'(seg);
  assign req_elem  = elem;
  assign req_seg   = seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      base_q <= '0; stride_q <= '0; estep_q <= '0; eoff <= '0; soff <= '0;
      idx_q <= '0; pred_q <= '0; vl_q <= '0; elem <= '0;
      seg_q <= '0; seg <= '0; rd_q <= '0; idx_mode_q <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start && reserved) begin
          err <= 1'b1;
        end else if (start) begin
          busy       <= 1'b1;
          base_q     <= base_addr;
          stride_q   <= stride_sel;
          estep_q    <= stride_sel * (AW'(seg_len) + AW'(1));
          idx_q      <= idx_offsets;
          idx_mode_q <= indexed;
          pred_q     <= pred_mask;
          vl_q       <= vec_len;
          seg_q      <= seg_len;
          rd_q       <= dest_reg;
          elem       <= '0;
          seg        <= '0;
          eoff       <= '0;
          soff       <= '0;
        end
      end else if (!in_range) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (step_elem) begin
        elem <= elem + LW'(1);
        seg  <= '0;
        soff <= '0;
        eoff <= eoff + estep_q;
        if (elem + LW'(1) >= vl_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (req_valid && req_ready) begin
        seg  <= seg + SW'(1);
        soff <= soff + stride_q;
      end
    end
  end
endmodule

module vldst_addr_gen_chk #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [4:0]    req_reg,
  input logic [SW-1:0] req_seg,
  input logic [SW-1:0] seg_q,
  input logic          done,
  input logic          err
);
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_reg));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !req_valid && !done);

  a_r10_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  a_r5_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_seg <= seg_q);
endmodule

bind vldst_addr_gen vldst_addr_gen_chk #(.AW(AW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_reg(req_reg),
  .req_seg(req_seg), .seg_q(seg_q), .done(done), .err(err)
);

// File: tb/vldst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module vldst_addr_gen_tb_top;
  localparam int AW = 32, MAXVL = 8, SW = 3, LW = 4;

  logic clk = 0, rst_n = 0, start = 0, const_stride = 0, indexed = 0, req_ready = 0;
  logic [2:0] width_code = 0;
  logic [AW-1:0] stride_val = 0, base_addr = 0;
  logic [MAXVL*AW-1:0] idx_offsets = 0;
  logic [LW-1:0] vec_len = 0;
  logic [SW-1:0] seg_len = 0;
  logic [MAXVL-1:0] pred_mask = 0;
  logic [4:0] dest_reg = 0;
  logic busy, req_valid, done, err;
  logic [AW-1:0] req_addr;
  logic [4:0] req_reg;
  logic [LW-1:0] req_elem;
  logic [SW-1:0] req_seg;

  always #2 clk = ~clk;

  vldst_addr_gen dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_addr [64];
  logic [4:0] exp_reg [64];
  int exp_elem [64], exp_seg [64];
  int exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] esize(input logic [2:0] c);
    case (c)
      3'd0: return AW / 8;
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 4;
      3'd4: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic build_expect();
    logic [AW-1:0] st, off;
    st = const_stride ? stride_val : esize(width_code);
    exp_n = 0;
    for (int i = 0; i < int'(vec_len); i++) begin
      if (pred_mask[i]) begin
        for (int j = 0; j <= int'(seg_len); j++) begin
          off = indexed ? idx_offsets[i*AW +: AW] : AW'(i * (int'(seg_len) + 1)) * st;
          exp_addr[exp_n] = base_addr + off + AW'(j) * st;
          exp_reg[exp_n]  = 5'(dest_reg + 5'(j));
          exp_elem[exp_n] = i;
          exp_seg[exp_n]  = j;
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_op(input string tag, input bit poke);
    int got, cyc;
    build_expect();
    @(negedge clk);
    start = 1;
    got = 0; cyc = 0;
    forever begin
      @(negedge clk);
      if (poke && cyc == 0) begin
        start = 1;
        base_addr = ~base_addr;
      end else start = 0;
      req_ready = ($urandom % 3) != 0;
      #1;
      if (req_valid && req_ready) begin
        if (got < exp_n) begin
          chk(req_addr == exp_addr[got], "R1/R2/R3", {tag, " addr"}, req_addr, exp_addr[got]);
          chk(req_reg == exp_reg[got], "R4", {tag, " reg"}, req_reg, exp_reg[got]);
          chk(int'(req_elem) == exp_elem[got] && int'(req_seg) == exp_seg[got], "R5",
              {tag, " order"}, {req_elem, req_seg}, {exp_elem[got][7:0], exp_seg[got][7:0]});
        end else chk(0, "R6", {tag, " extra beat"}, got, exp_n);
        got++;
      end
      if (done) break;
      cyc++;
      if (cyc > 2000) begin
        chk(0, "R9", {tag, " no done"}, 0, 1);
        break;
      end
    end
    start = 0;
    chk(got == exp_n, "R6/R9", {tag, " beat count at done"}, got, exp_n);
    @(negedge clk);
    req_ready = 0;
    #1;
    chk(!done && !busy, "R9", {tag, " done one cycle"}, {done, busy}, 0);
  endtask

  task automatic set_op(input logic [2:0] wc, input bit cs, input logic [AW-1:0] sv,
                        input bit ix, input logic [AW-1:0] b, input int vl, input int sl,
                        input logic [MAXVL-1:0] pm, input logic [4:0] rd);
    width_code = wc; const_stride = cs; stride_val = sv; indexed = ix;
    base_addr = b; vec_len = LW'(vl); seg_len = SW'(sl); pred_mask = pm; dest_reg = rd;
    for (int i = 0; i < MAXVL; i++) idx_offsets[i*AW +: AW] = $urandom;
  endtask

  task automatic reserved_op(input logic [2:0] wc);
    set_op(wc, 0, 0, 0, 32'h1000, 4, 1, 8'hff, 3);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    req_ready = 1;
    #1;
    chk(err == 1 && !busy, "R7", "err pulse", {err, busy}, 2'b10);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      chk(!req_valid && !done && !err && !busy, "R7", "quiet after err",
          {req_valid, done, err, busy}, 0);
    end
    req_ready = 0;
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #10;
    chk(!busy && !req_valid && !done && !err, "R9", "reset state",
        {busy, req_valid, done, err}, 0);
    rst_n = 1;

    set_op(3'd3, 0, 0, 0, 32'h1000, 4, 0, 8'hff, 5);        run_op("R1 unit w4", 0);
    set_op(3'd0, 0, 0, 0, 32'h2000, 3, 2, 8'hff, 30);       run_op("R1 xlen seg3 R4 wrap", 0);
    set_op(3'd5, 0, 0, 0, 32'hfffffff0, 2, 1, 8'h03, 0);    run_op("R1 w16 addr wrap", 0);
    set_op(3'd1, 1, 32'd100, 0, 32'h4000, 5, 2, 8'h1f, 1);  run_op("R2 const seg", 0);
    set_op(3'd4, 1, 32'hfffffff8, 0, 32'h8000, 4, 1, 8'hff, 2); run_op("R2 negative", 0);
    set_op(3'd2, 0, 0, 1, 32'h100, 8, 1, 8'hff, 7);         run_op("R3 indexed", 0);
    set_op(3'd3, 1, 32'd12, 1, 32'h300, 6, 2, 8'h2d, 9);    run_op("R3 R6 idx masked", 0);
    set_op(3'd3, 0, 0, 0, 32'h500, 8, 0, 8'ha5, 4);         run_op("R6 sparse", 0);
    set_op(3'd3, 0, 0, 0, 32'h500, 8, 3, 8'h00, 4);         run_op("R6 R9 all masked", 0);
    set_op(3'd3, 0, 0, 0, 32'h500, 0, 1, 8'hff, 4);         run_op("R9 vl zero", 0);
    set_op(3'd2, 0, 0, 0, 32'h700, 8, 7, 8'hff, 20);        run_op("R5 max seg", 0);
    set_op(3'd3, 0, 0, 0, 32'h900, 4, 1, 8'hff, 6);         run_op("R10 start ignored", 1);
    reserved_op(3'd6);
    reserved_op(3'd7);

    for (int n = 0; n < 40; n++) begin
      set_op(3'($urandom % 6), 1'($urandom), AW'($urandom % 64), 1'($urandom),
             $urandom, int'($urandom % (MAXVL + 1)), int'($urandom % 4),
             MAXVL'($urandom), 5'($urandom));
      run_op("rand", 1'($urandom % 5 == 0) && vec_len != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule